// File: doc/BRIEF.md
# PWM Tick Generator with Two-Stage Clock Scaling

This block turns one bus clock into single-cycle enable pulses ("ticks") for a bank of eight PWM channel counters. No clock is gated or derived: every output is an enable that is high for exactly one bus-clock cycle, and the downstream counters advance only on those cycles.

The block has two groups, A and B. In each group a power-of-two prescaler produces a primary tick. A second divider counts primary ticks and produces a scaled tick once every 2×N primary ticks, where N is an 8-bit scale value and zero stands for 256. Each channel has a fixed group and picks either its group's primary tick or its group's scaled tick with its own select bit. Whenever a group's prescale code or scale value changes, the affected dividers restart from their initial state, so the first period after a change is a whole period.

Top module: `pwm_tick_gen`

## Requirements
- R1: With group prescale code k (0..7) held, the primary tick of that group is high once every 2^k bus cycles, counted from the cycle after a restart; code 0 makes it high on every cycle.
- R2: The A prescale code is `presc_cfg[2:0]` and the B code is `presc_cfg[6:4]`; bits 3 and 7 have no effect on any output.
- R3: With scale value N (1..255) held, the scaled tick of a group is high on every 2N-th primary tick of that group after a restart, and only on a cycle where that primary tick is high.
- R4: A scale value of 0 makes the scaled tick fire on every 512th primary tick; a value of 1 makes it fire on every second primary tick.
- R5: Channels 0, 1, 4 and 5 take their ticks from group A; channels 2, 3, 6 and 7 from group B.
- R6: `src_sel[i]` = 1 routes the group's scaled tick to `ch_tick[i]`; `src_sel[i]` = 0 routes the group's primary tick.
- R7: In a cycle where a group's prescale code differs from the one applied in the previous cycle, neither tick of that group is high and both of its dividers restart; a change of the scale value alone restarts only the scaled divider and suppresses only the scaled tick in that cycle.
- R8: While reset is asserted every output is low; after reset all counters and the remembered configuration are zero, and each tick with a divisor above one is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_cfg | input | 8 | Prescale codes: A in [2:0], B in [6:4] |
| scale_a | input | 8 | Scale value N for group A (0 means 256) |
| scale_b | input | 8 | Scale value N for group B (0 means 256) |
| src_sel | input | 8 | Per-channel choice: 1 scaled tick, 0 primary tick |
| tick_a | output | 1 | Primary tick of group A |
| tick_b | output | 1 | Primary tick of group B |
| tick_sa | output | 1 | Scaled tick of group A |
| tick_sb | output | 1 | Scaled tick of group B |
| ch_tick | output | 8 | Per-channel tick enable |

## Verification
The assertions assume the configuration inputs are synchronous to the bus clock and may change on any cycle; they judge a change only against the value sampled on the previous edge, so a change right after reset is legal. The single-cycle pulse properties only apply when the code was stable across the pair of cycles, since a change forces a restart. The stimulus changes configuration only between clock edges, holds it for long stretches to let whole periods elapse, and also applies bursts of rapid changes so the restart rule is exercised alongside steady running.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  localparam int unsigned NUM_GROUPS = 2;

  // Terminal count of a power-of-two prescaler for a given code.
  function automatic int unsigned pri_last(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

  // Terminal count of the scaled divider's inner counter; zero means full range.
  function automatic int unsigned sec_last(input int unsigned scale,
                                           input int unsigned width);
    if (scale == 0) return (32'd1 << width) - 32'd1;
    return scale - 32'd1;
  endfunction

  // Group owning a channel: bit 1 of the channel index.
  function automatic int unsigned chan_group(input int unsigned ch);
    return (ch >> 1) & 32'd1;
  endfunction

endpackage

// File: rtl/pwm_pri_div.sv
module pwm_pri_div
  import pwm_tick_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic              tick,
  output logic              restart
);
  localparam int unsigned CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  cnt;
  logic              at_last;

  assign restart = (code != code_q);
  assign at_last = (cnt == CNT_W'(pri_last(32'(code))));
  assign tick    = rst_n && !restart && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt    <= '0;
    end else begin
      code_q <= code;
      if (restart || at_last) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_sec_div.sv
module pwm_sec_div
  import pwm_tick_pkg::*;
#(
  parameter int unsigned SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pri_tick,
  input  logic               pri_restart,
  input  logic [SCALE_W-1:0] scale,
  output logic               tick
);
  logic [SCALE_W-1:0] scale_q;
  logic [SCALE_W-1:0] cnt;
  logic               phase;
  logic               restart;
  logic               wrap;

  assign restart = pri_restart || (scale != scale_q);
  assign wrap    = pri_tick && (cnt == SCALE_W'(sec_last(32'(scale), SCALE_W)));
  assign tick    = wrap && phase && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= '0;
      cnt     <= '0;
      phase   <= 1'b0;
    end else begin
      scale_q <= scale;
      if (restart) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (wrap) begin
        cnt   <= '0;
        phase <= ~phase;
      end else if (pri_tick) begin
        cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_tick_route.sv
module pwm_tick_route
  import pwm_tick_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_GROUPS-1:0] pri_tick,
  input  logic [NUM_GROUPS-1:0] sec_tick,
  input  logic [NUM_CH-1:0]     sel,
  output logic [NUM_CH-1:0]     ch_tick
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int unsigned GRP = chan_group(i);
    assign ch_tick[i] = sel[i] ? sec_tick[GRP] : pri_tick[GRP];
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_tick_pkg::*;
#(
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned SCALE_W = 8,
  parameter int unsigned NUM_CH  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_GROUPS*(CODE_W+1)-1:0] presc_cfg,
  input  logic [SCALE_W-1:0]             scale_a,
  input  logic [SCALE_W-1:0]             scale_b,
  input  logic [NUM_CH-1:0]              src_sel,
  output logic                           tick_a,
  output logic                           tick_b,
  output logic                           tick_sa,
  output logic                           tick_sb,
  output logic [NUM_CH-1:0]              ch_tick
);
  localparam int unsigned FIELD_W = CODE_W + 1;

  // Named internal events, one bit per group.
  logic [NUM_GROUPS-1:0] pri_tick_ev;
  logic [NUM_GROUPS-1:0] pri_restart_ev;
  logic [NUM_GROUPS-1:0] sec_tick_ev;
  logic [SCALE_W-1:0]    scale_grp [NUM_GROUPS];

  assign scale_grp[0] = scale_a;
  assign scale_grp[1] = scale_b;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pwm_pri_div #(.CODE_W(CODE_W)) u_pri (
      .clk     (clk),
      .rst_n   (rst_n),
      .code    (presc_cfg[g*FIELD_W +: CODE_W]),
      .tick    (pri_tick_ev[g]),
      .restart (pri_restart_ev[g])
    );
    pwm_sec_div #(.SCALE_W(SCALE_W)) u_sec (
      .clk         (clk),
      .rst_n       (rst_n),
      .pri_tick    (pri_tick_ev[g]),
      .pri_restart (pri_restart_ev[g]),
      .scale       (scale_grp[g]),
      .tick        (sec_tick_ev[g])
    );
  end

  pwm_tick_route #(.NUM_CH(NUM_CH)) u_route (
    .pri_tick (pri_tick_ev),
    .sec_tick (sec_tick_ev),
    .sel      (src_sel),
    .ch_tick  (ch_tick)
  );

  assign tick_a  = pri_tick_ev[0];
  assign tick_b  = pri_tick_ev[1];
  assign tick_sa = sec_tick_ev[0];
  assign tick_sb = sec_tick_ev[1];
endmodule

// File: rtl/pwm_tick_gen_chk.sv
module pwm_tick_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] presc_cfg,
  input logic [7:0] src_sel,
  input logic       tick_a,
  input logic       tick_b,
  input logic       tick_sa,
  input logic       tick_sb,
  input logic [7:0] ch_tick
);
  always @(negedge clk) begin
    if (!rst_n) AST_QUIET_IN_RESET: assert (ch_tick == '0 && !tick_a && !tick_b); // R8
  end

  AST_CODE0_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_cfg[2:0] == 3'd0 && $stable(presc_cfg[2:0])) |-> tick_a); // R1

  AST_SCALED_NEEDS_PRIMARY_A: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sa |-> tick_a); // R3

  AST_SCALED_NEEDS_PRIMARY_B: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sb |-> tick_b); // R3

  AST_SCALED_SINGLE_A: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sa |=> !tick_sa); // R3

  AST_CH0_FROM_GROUP_A: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tick[0] |-> (tick_a || tick_sa)); // R5

  AST_CH2_FROM_GROUP_B: assert property (@(posedge clk) disable iff (!rst_n)
    ch_tick[2] |-> (tick_b || tick_sb)); // R5

  AST_SEL_PRIMARY_CH6: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sel[6] && tick_b) |-> ch_tick[6]); // R6

  AST_NEW_CODE_SILENT_A: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presc_cfg[2:0]) |-> (!tick_a && !tick_sa)); // R7

  AST_NEW_CODE_SILENT_B: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(presc_cfg[6:4]) |-> (!tick_b && !tick_sb)); // R7

  AST_PULSE_ONE_CYCLE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && presc_cfg[2:0] != 3'd0) |=> !tick_a); // R8
endmodule

bind pwm_tick_gen pwm_tick_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .presc_cfg (presc_cfg),
  .src_sel   (src_sel),
  .tick_a    (tick_a),
  .tick_b    (tick_b),
  .tick_sa   (tick_sa),
  .tick_sb   (tick_sb),
  .ch_tick   (ch_tick)
);

// File: tb/sim_pwm_tick_gen.sv
`timescale 1ns/1ps
module sim_pwm_tick_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] presc_cfg = 8'h00;
  logic [7:0] scale_a = 8'h00;
  logic [7:0] scale_b = 8'h00;
  logic [7:0] src_sel = 8'h00;
  logic       tick_a, tick_b, tick_sa, tick_sb;
  logic [7:0] ch_tick;

  always #2.5 clk = ~clk;

  pwm_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .presc_cfg(presc_cfg), .scale_a(scale_a),
    .scale_b(scale_b), .src_sel(src_sel), .tick_a(tick_a), .tick_b(tick_b),
    .tick_sa(tick_sa), .tick_sb(tick_sb), .ch_tick(ch_tick)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference: cycles and primary ticks since each restart.
  int m_cyc [2];
  int m_pt  [2];
  int m_code[2];
  int m_scl [2];

  // Directed counters
  int n_sa, n_sb, n_ch0, n_ch2, n_ch4;

  task automatic model_reset();
    for (int g = 0; g < 2; g++) begin
      m_cyc[g] = 0; m_pt[g] = 0; m_code[g] = 0; m_scl[g] = 0;
    end
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called right after a negedge with inputs already set.
  task automatic step();
    int code[2];
    int scl[2];
    bit ep[2];
    bit es[2];
    bit rp, rs;
    int n;
    #1;
    code[0] = presc_cfg[2:0];
    code[1] = presc_cfg[6:4];
    scl[0] = scale_a;
    scl[1] = scale_b;
    if (!rst_n) begin
      chk("R8", "outputs in reset", {tick_a, tick_b, tick_sa, tick_sb, ch_tick}, 0);
      model_reset();
    end else begin
      for (int g = 0; g < 2; g++) begin
        rp = (code[g] != m_code[g]);
        rs = rp || (scl[g] != m_scl[g]);
        n = (scl[g] == 0) ? 256 : scl[g];
        ep[g] = !rp && (((m_cyc[g] + 1) % (1 << code[g])) == 0);
        es[g] = ep[g] && !rs && (((m_pt[g] + 1) % (2 * n)) == 0);
        if (rp) m_cyc[g] = 0; else m_cyc[g] = (m_cyc[g] + 1) % 128;
        if (rs) m_pt[g] = 0; else if (ep[g]) m_pt[g] = (m_pt[g] + 1) % 512;
        m_code[g] = code[g];
        m_scl[g] = scl[g];
      end
      chk("R1", "tick_a", tick_a, ep[0]);
      chk("R1", "tick_b", tick_b, ep[1]);
      chk("R3", "tick_sa", tick_sa, es[0]);
      chk("R3", "tick_sb", tick_sb, es[1]);
      for (int i = 0; i < 8; i++) begin
        int g;
        g = (i >> 1) & 1;
        chk("R6", $sformatf("ch_tick[%0d]", i), ch_tick[i],
            src_sel[i] ? es[g] : ep[g]);
      end
      n_sa += tick_sa; n_sb += tick_sb;
      n_ch0 += ch_tick[0]; n_ch2 += ch_tick[2]; n_ch4 += ch_tick[4];
    end
    @(negedge clk);
  endtask

  task automatic run(input logic [7:0] p, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] s, input int cycles);
    presc_cfg = p; scale_a = a; scale_b = b; src_sel = s;
    n_sa = 0; n_sb = 0; n_ch0 = 0; n_ch2 = 0; n_ch4 = 0;
    for (int c = 0; c < cycles; c++) step();
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    for (int c = 0; c < 4; c++) step();      // R8 reset state
    rst_n = 1'b1;

    // R1: code 0 after reset, every cycle
    run(8'h00, 8'h00, 8'h00, 8'h00, 40);
    chk("R1", "code0 tick count", n_ch0, 40);

    // R5: A code 1, B code 2, primary selection, 64 cycles incl. restart
    run(8'h21, 8'h00, 8'h00, 8'h00, 64);
    chk("R5", "ch0 count (group A /2)", n_ch0, 31);
    chk("R5", "ch4 count (group A /2)", n_ch4, 31);
    chk("R5", "ch2 count (group B /4)", n_ch2, 15);

    // R4: scale 0 -> /512, scale 1 -> /2, group A channels on scaled tick
    run(8'h00, 8'h00, 8'h01, 8'h33, 1100);
    chk("R4", "tick_sa count scale 0", n_sa, 2);
    chk("R4", "ch0 scaled count", n_ch0, 2);
    chk("R4", "tick_sb count scale 1", n_sb, 549);

    // R2: unused bits 3 and 7 set; codes A=5, B=3
    run(8'hB5, 8'h03, 8'h07, 8'hCC, 3000);
    run(8'h35, 8'h03, 8'h07, 8'hCC, 400);   // clearing unused bits must not restart
    chk("R2", "ch0 primary count A/32 over 400", n_ch0 >= 12 && n_ch0 <= 13, 1);

    // R7: scale change mid-period
    run(8'h74, 8'd200, 8'd2, 8'hA5, 500);
    run(8'h74, 8'd201, 8'd2, 8'hA5, 2000);

    // R7: rapid configuration changes
    for (int k = 0; k < 40; k++)
      run($urandom & 8'h77, $urandom % 4, $urandom % 3, $urandom, 30 + k);

    // R8: reset mid-run
    rst_n = 1'b0;
    for (int c = 0; c < 3; c++) step();
    rst_n = 1'b1;
    run(8'h12, 8'd1, 8'd1, 8'hFF, 300);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule